// File: doc/BRIEF.md
# System Management Interrupt Sequencer

This block sits beside a simple processor core. It watches an asynchronous, active-low management interrupt line and turns each high-to-low transition into a pending request. It grants entry to management mode only at a point where the core may legally stop: an instruction boundary or a single iteration of a repeated string operation. It never grants entry while the core holds a locked bus sequence.

When entry is granted, the block raises a one-cycle entry request toward the core. This request takes priority over any maskable interrupt presented in the same cycle. An active-low mode flag then stays asserted until the core reports that the resume instruction has executed. The block stores one further request that arrives while the mode is active. That request is served only after the resume, and the mode flag is released for at least one cycle before the next entry.

Top module: `smi_sequencer`

## Requirements
- R1: While rst_n is low, mode_act_n is 1, enter_req is 0 and no request is pending, and the synchronizer holds the idle (high) level.
- R2: A request is captured only on a high-to-low transition of smi_req_n. The line passes through SYNC_STAGES flops (default 2) and one edge-detect flop, so the edge is seen in the third clock after the line is sampled low. Holding the line low produces exactly one request.
- R3: enter_req is 1 for a cycle exactly when a request is pending, core_boundary or core_rep_iter is 1, core_locked is 0 and the mode is not active. The pending request clears at that clock edge.
- R4: A core_rep_iter strobe with core_boundary at 0 is a legal entry point, the same as a boundary strobe.
- R5: While core_locked is 1, a pending request is kept and not granted. It is granted at the first legal point after core_locked returns to 0.
- R6: mode_act_n goes low in the cycle after enter_req and stays low until a core_resume strobe. It is high from the cycle after the resume.
- R7: A falling edge while the mode is active sets the pending flag. No entry is granted before the resume, and mode_act_n is high for at least one cycle before the next enter_req.
- R8: Only one request is stored. Further falling edges while a request is pending have no effect, so one resume is followed by exactly one further entry.
- R9: irq_fwd follows irq_req, except that it is 0 in any cycle in which enter_req is 1.
- R10: A core_resume strobe while the mode is inactive has no effect on mode_act_n or on a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smi_req_n | input | 1 | Raw active-low management interrupt line (asynchronous) |
| core_boundary | input | 1 | One-cycle instruction-boundary strobe from the core |
| core_rep_iter | input | 1 | One-cycle strobe at each repeated-string iteration |
| core_locked | input | 1 | High while a locked bus sequence is in progress |
| core_resume | input | 1 | One-cycle strobe when the resume instruction executes |
| irq_req | input | 1 | Maskable interrupt request from the interrupt controller |
| enter_req | output | 1 | One-cycle request to the core to enter management mode |
| irq_fwd | output | 1 | Maskable request passed on to the core |
| mode_act_n | output | 1 | Active-low management-mode indicator |

## Verification
The bench holds the line low across many boundary strobes, so a level-triggered design would re-enter over and over. It presents boundaries while locked, so a design that ignores the lock would enter in the middle of an atomic sequence. It drives a boundary strobe in the same cycle as the resume and in the cycle right after it, which catches a design that re-enters with no high gap on the mode flag or that drops a request arriving during the mode. It also sends several edges while a request is pending, and a stray resume while idle, which expose an unbounded request count and a resume that is not gated by the mode state.

// File: rtl/smi_seq_pkg.sv
package smi_seq_pkg;
  typedef enum logic {
    MODE_OFF = 1'b0,
    MODE_ON  = 1'b1
  } smi_mode_e;

  localparam int unsigned SMI_SYNC_MIN = 2;
endpackage

// File: rtl/smi_edge_capture.sv
module smi_edge_capture #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic fall_seen
);
  localparam int unsigned CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  // shift the raw level in at bit 0; the last bit is the delayed copy for edge detect
  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], line_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign fall_seen = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];
endmodule

// File: rtl/smi_req_latch.sv
module smi_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_seen,
  input  logic grant,
  output logic pending
);
  logic pend_q;
  logic pend_d;
  logic pend_en;

  // a new edge wins over the clear, so a request landing on a grant is kept
  always_comb begin
    pend_en = fall_seen | grant;
    pend_d  = fall_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pending = pend_q;
endmodule

// File: rtl/smi_entry_gate.sv
module smi_entry_gate (
  input  logic pending,
  input  logic mode_on,
  input  logic at_boundary,
  input  logic at_rep_iter,
  input  logic locked,
  input  logic irq_in,
  output logic grant,
  output logic irq_out
);
  logic legal_point;

  always_comb begin
    legal_point = at_boundary | at_rep_iter;
    grant       = pending & legal_point & ~locked & ~mode_on;
    irq_out     = irq_in & ~grant;
  end
endmodule

// File: rtl/smi_mode_track.sv
module smi_mode_track
  import smi_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic resume,
  output logic mode_on,
  output logic mode_n
);
  smi_mode_e st_q;
  smi_mode_e st_d;
  logic      st_en;

  always_comb begin
    st_d  = st_q;
    st_en = 1'b0;
    unique case (st_q)
      MODE_OFF: if (grant)  begin st_d = MODE_ON;  st_en = 1'b1; end
      MODE_ON:  if (resume) begin st_d = MODE_OFF; st_en = 1'b1; end
      default:  begin st_d = MODE_OFF; st_en = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= MODE_OFF;
    else if (st_en) st_q <= st_d;
  end

  assign mode_on = (st_q == MODE_ON);
  assign mode_n  = ~mode_on;
endmodule

// File: rtl/smi_sequencer.sv
module smi_sequencer #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smi_req_n,
  input  logic core_boundary,
  input  logic core_rep_iter,
  input  logic core_locked,
  input  logic core_resume,
  input  logic irq_req,
  output logic enter_req,
  output logic irq_fwd,
  output logic mode_act_n
);
  localparam int unsigned STAGES_EFF =
    (SYNC_STAGES < smi_seq_pkg::SMI_SYNC_MIN) ? smi_seq_pkg::SMI_SYNC_MIN : SYNC_STAGES;

  logic fall_seen;
  logic pending;
  logic grant;
  logic mode_on;

  smi_edge_capture #(.STAGES(STAGES_EFF)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_n    (smi_req_n),
    .fall_seen (fall_seen)
  );

  smi_req_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_seen (fall_seen),
    .grant     (grant),
    .pending   (pending)
  );

  smi_entry_gate u_gate (
    .pending     (pending),
    .mode_on     (mode_on),
    .at_boundary (core_boundary),
    .at_rep_iter (core_rep_iter),
    .locked      (core_locked),
    .irq_in      (irq_req),
    .grant       (grant),
    .irq_out     (irq_fwd)
  );

  smi_mode_track u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .grant   (grant),
    .resume  (core_resume),
    .mode_on (mode_on),
    .mode_n  (mode_act_n)
  );

  assign enter_req = grant;
endmodule

// File: rtl/smi_sequencer_chk.sv
module smi_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic core_boundary,
  input logic core_rep_iter,
  input logic core_locked,
  input logic core_resume,
  input logic irq_req,
  input logic enter_req,
  input logic irq_fwd,
  input logic mode_act_n
);
  // R3
  entry_at_legal_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_req |-> (core_boundary || core_rep_iter));

  // R5
  no_entry_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_req |-> !core_locked);

  // R7
  no_entry_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_req |-> mode_act_n);

  // R6
  mode_follows_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_req |=> !mode_act_n);

  // R6
  mode_held_until_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_act_n && !core_resume) |=> !mode_act_n);

  // R6
  mode_ends_on_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_act_n && core_resume) |=> mode_act_n);

  // R9
  irq_yields_to_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_req |-> !irq_fwd);

  // R9
  irq_passes_otherwise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enter_req && irq_req) |-> irq_fwd);

  // R10
  idle_resume_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act_n && !enter_req) |=> mode_act_n);
endmodule

bind smi_sequencer smi_sequencer_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_boundary (core_boundary),
  .core_rep_iter (core_rep_iter),
  .core_locked   (core_locked),
  .core_resume   (core_resume),
  .irq_req       (irq_req),
  .enter_req     (enter_req),
  .irq_fwd       (irq_fwd),
  .mode_act_n    (mode_act_n)
);

// File: tb/smi_sequencer_tb_top.sv
`timescale 1ns/1ps
module smi_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic smi_req_n, core_boundary, core_rep_iter, core_locked, core_resume, irq_req;
  logic enter_req, irq_fwd, mode_act_n;

  int checks = 0;
  int fails  = 0;
  int enters = 0;

  // reference model state
  bit samp_q[$];
  bit m_pend;
  bit m_mode;

  always #4 clk = ~clk;

  smi_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .smi_req_n(smi_req_n),
    .core_boundary(core_boundary), .core_rep_iter(core_rep_iter),
    .core_locked(core_locked), .core_resume(core_resume), .irq_req(irq_req),
    .enter_req(enter_req), .irq_fwd(irq_fwd), .mode_act_n(mode_act_n)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    samp_q = '{1'b1, 1'b1, 1'b1};
    m_pend = 1'b0;
    m_mode = 1'b0;
  endtask

  // one cycle: drive at negedge, compare, then advance the model across the next posedge
  task automatic step(input bit raw, input bit bnd, input bit rep, input bit lck,
                      input bit res, input bit irq, input string tag);
    bit fall, grant;
    int n;
    @(negedge clk);
    smi_req_n = raw; core_boundary = bnd; core_rep_iter = rep;
    core_locked = lck; core_resume = res; irq_req = irq;
    #1;
    n     = samp_q.size();
    fall  = samp_q[n-3] & ~samp_q[n-2];
    grant = m_pend & (bnd | rep) & ~lck & ~m_mode;
    check(tag, "enter_req", enter_req, grant);
    check(tag, "irq_fwd", irq_fwd, irq & ~grant);
    check(tag, "mode_act_n", mode_act_n, ~m_mode);
    if (enter_req === 1'b1) enters++;
    if (fall)       m_pend = 1'b1;
    else if (grant) m_pend = 1'b0;
    if (grant)           m_mode = 1'b1;
    else if (res && m_mode) m_mode = 1'b0;
    samp_q.push_back(raw);
    if (samp_q.size() > 8) void'(samp_q.pop_front());
  endtask

  task automatic idle(input int cyc, input bit raw, input string tag);
    for (int i = 0; i < cyc; i++) step(raw, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smi_req_n = 1'b1; core_boundary = 0; core_rep_iter = 0;
    core_locked = 0; core_resume = 0; irq_req = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state, also with a low line and strobes present
    smi_req_n = 1'b0; core_boundary = 1'b1;
    #1;
    check("R1", "mode_act_n", mode_act_n, 1'b1);
    check("R1", "enter_req", enter_req, 1'b0);
    smi_req_n = 1'b1; core_boundary = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(3, 1, "R1");

    // R2: line held low across many boundaries -> exactly one entry
    enters = 0;
    idle(2, 0, "R2");
    for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 0, 0, "R3");
    check("R2", "entries for one held edge", enters == 1, 1'b1);
    idle(3, 0, "R6");
    step(0, 0, 0, 0, 1, 0, "R6");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0, 1, "R2");

    // R5 lock blocks; R4 repeat iteration grants; R9 priority over irq
    idle(2, 1, "R5");
    idle(4, 0, "R5");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 0, 1, "R5");
    step(0, 0, 1, 1, 0, 1, "R5");
    step(0, 0, 1, 0, 0, 1, "R4");
    step(0, 0, 0, 0, 0, 1, "R9");

    // R7/R8: several edges during the mode, boundaries in mode, resume with boundary
    for (int k = 0; k < 3; k++) begin
      idle(2, 1, "R8");
      step(0, 1, 0, 0, 0, 0, "R7");
      idle(3, 0, "R8");
    end
    enters = 0;
    step(0, 1, 0, 0, 1, 0, "R7");
    step(0, 1, 0, 0, 0, 1, "R7");
    idle(2, 0, "R6");
    step(0, 0, 0, 0, 1, 0, "R8");
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 0, 0, "R8");
    check("R8", "entries after pile-up", enters == 1, 1'b1);

    // R10: stray resume while idle, with a pending request
    idle(2, 1, "R10");
    idle(4, 0, "R10");
    step(0, 0, 0, 0, 1, 1, "R10");
    step(0, 0, 0, 0, 1, 0, "R10");
    step(0, 1, 0, 0, 0, 1, "R10");
    idle(3, 0, "R10");
    step(0, 0, 0, 0, 1, 0, "R6");
    idle(3, 1, "R6");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule